// File: doc/BRIEF.md
# Coherent Two-Byte Register Reader

This block is the read path of a byte-addressed register space. The space holds live 16-bit measurement values, and each value is split over two consecutive byte addresses. Measurement logic outside the block keeps changing these values at any time. A host reads through a byte interface. A read command is framed by a start strobe and an end strobe, and it may contain several single-byte read requests.

When the high byte of a pair is read, the block captures the low byte of the same pair in that same cycle. The captured byte is held until the command ends. A later low-byte read of that pair inside the same command returns the captured half, even if the live value has moved since then. The host therefore sees a 16-bit value with no tearing, provided it reads the high byte first and both halves in one command.

The lowest 32 byte addresses are the register region. Any address from 32 upward goes straight to a separate memory port. Such an address never touches the holding latch.

Top module: `pair_snap_reader`

## Requirements
- R1: While reset is asserted and directly after it, `rd_valid` and `mem_req` are 0 and `rd_data` is 0.
- R2: A request to an address below 32 returns the live byte at that address on `rd_data`, with `rd_valid` high, in the cycle after the request. In that cycle `live_regs` byte N sits at bits [8N+7:8N].
- R3: A request to an even address 2k below 32 is a high-byte read of pair k. It captures the live byte at 2k+1. A later read of 2k+1 in the same command returns the captured byte, even if the live byte has changed.
- R4: A pulse on `cmd_end` releases the captured byte. A later read of the low byte returns the live value.
- R5: A low-byte read of a pair other than the captured one returns the live value.
- R6: A high-byte read of a different pair replaces the capture. The low byte of the earlier pair then reads live, and the low byte of the new pair reads captured.
- R7: A request to address 32 or above raises `mem_req` in the same cycle, with `mem_addr` equal to `rd_addr`. In the next cycle `rd_data` shows `mem_rdata`. The request leaves the captured byte unchanged.
- R8: Reading the same high byte again in one command re-captures its pair from the current live values.
- R9: A pulse on `cmd_start` discards any capture left from before.
- R10: A high-byte read in the same cycle as `cmd_end` returns the live high byte and leaves nothing captured.
- R11: A cycle with no request is followed by a cycle with `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_regs | input | 256 | Live bytes of the 32-byte register region; byte N at [8N+7:8N] |
| cmd_start | input | 1 | One-cycle pulse opening a read command |
| cmd_end | input | 1 | One-cycle pulse closing a read command |
| rd_req | input | 1 | Byte read request |
| rd_addr | input | 8 | Byte address of the request |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_req |
| mem_req | output | 1 | Forwarded request for addresses 32 and above |
| mem_addr | output | 8 | Address of the forwarded request |
| mem_rdata | input | 8 | Memory read data, expected one cycle after mem_req |

## Verification
The assertions rely on the memory answering every forwarded request one cycle after `mem_req`. They also rely on at most one byte request per cycle, and on the host reading the low byte right after its high byte inside a command that neither starts nor ends in between. The bench meets these conditions with a one-cycle memory model whose data is a fixed function of the address. Every read goes through a single task that raises the request for one cycle. The command strobes fall only in cycles chosen by the scenario. Live values change only between reads, at the falling clock edge.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // Origin of the byte presented on the read data output.
  typedef enum logic {
    SRC_REG = 1'b0,
    SRC_MEM = 1'b1
  } psr_src_e;

endpackage

// File: rtl/psr_decode.sv
module psr_decode #(
  parameter int ADDR_W    = 8,
  parameter int REG_BYTES = 32,
  localparam int REG_AW   = $clog2(REG_BYTES),
  localparam int PAIR_W   = REG_AW - 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_reg,
  output logic              is_msb,
  output logic [PAIR_W-1:0] pair_idx,
  output logic [REG_AW-1:0] reg_off
);

  // Register region is the low REG_BYTES addresses; above it is memory.
  always_comb begin
    is_reg   = (addr[ADDR_W-1:REG_AW] == '0);
    reg_off  = addr[REG_AW-1:0];
    pair_idx = addr[REG_AW-1:1];
    // High byte of a pair sits at the even address.
    is_msb   = is_reg && !addr[0];
  end

endmodule

// File: rtl/psr_hold.sv
module psr_hold #(
  parameter int DATA_W = 8,
  parameter int PAIR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_end,
  input  logic              load,
  input  logic [PAIR_W-1:0] load_pair,
  input  logic [DATA_W-1:0] load_lsb,
  output logic              held,
  output logic [PAIR_W-1:0] held_pair,
  output logic [DATA_W-1:0] held_lsb
);

  logic              held_q, held_d;
  logic [PAIR_W-1:0] pair_q, pair_d;
  logic [DATA_W-1:0] lsb_q, lsb_d;
  logic              data_en;

  // End of command has top priority, then a capture, then a fresh start.
  always_comb begin
    held_d  = held_q;
    pair_d  = pair_q;
    lsb_d   = lsb_q;
    data_en = 1'b0;
    if (cmd_end) begin
      held_d = 1'b0;
    end else if (load) begin
      held_d  = 1'b1;
      pair_d  = load_pair;
      lsb_d   = load_lsb;
      data_en = 1'b1;
    end else if (cmd_start) begin
      held_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      lsb_q  <= '0;
    end else if (data_en) begin
      pair_q <= pair_d;
      lsb_q  <= lsb_d;
    end
  end

  assign held      = held_q;
  assign held_pair = pair_q;
  assign held_lsb  = lsb_q;

endmodule

// File: rtl/psr_outmux.sv
module psr_outmux
  import psr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  psr_src_e          src,
  input  logic [DATA_W-1:0] reg_byte,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic              valid_q, valid_d;
  psr_src_e          src_q, src_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    valid_d = req;
    src_d   = src_q;
    data_d  = data_q;
    if (req) begin
      src_d = src;
      if (src == SRC_REG) begin
        data_d = reg_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= SRC_REG;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (req) begin
        src_q  <= src_d;
        data_q <= data_d;
      end
    end
  end

  // Memory answers one cycle after its request, so it is passed through.
  assign rd_data  = (src_q == SRC_MEM) ? mem_rdata : data_q;
  assign rd_valid = valid_q;

endmodule

// File: rtl/pair_snap_reader.sv
module pair_snap_reader
  import psr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int REG_BYTES = 32,
  localparam int REG_AW   = $clog2(REG_BYTES),
  localparam int PAIR_W   = REG_AW - 1,
  localparam int LIVE_W   = REG_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LIVE_W-1:0] live_regs,
  input  logic              cmd_start,
  input  logic              cmd_end,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [DATA_W-1:0] live_byte [REG_BYTES];

  for (genvar gi = 0; gi < REG_BYTES; gi++) begin : g_unpack
    assign live_byte[gi] = live_regs[gi*DATA_W +: DATA_W];
  end

  logic              is_reg;
  logic              is_msb;
  logic [PAIR_W-1:0] pair_idx;
  logic [REG_AW-1:0] reg_off;

  psr_decode #(
    .ADDR_W   (ADDR_W),
    .REG_BYTES(REG_BYTES)
  ) u_decode (
    .addr    (rd_addr),
    .is_reg  (is_reg),
    .is_msb  (is_msb),
    .pair_idx(pair_idx),
    .reg_off (reg_off)
  );

  logic              cap_load;
  logic [DATA_W-1:0] cap_lsb_in;
  logic              held;
  logic [PAIR_W-1:0] held_pair;
  logic [DATA_W-1:0] held_lsb;

  always_comb begin
    cap_load   = rd_req && is_msb;
    cap_lsb_in = live_byte[{pair_idx, 1'b1}];
  end

  psr_hold #(
    .DATA_W(DATA_W),
    .PAIR_W(PAIR_W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_start(cmd_start),
    .cmd_end  (cmd_end),
    .load     (cap_load),
    .load_pair(pair_idx),
    .load_lsb (cap_lsb_in),
    .held     (held),
    .held_pair(held_pair),
    .held_lsb (held_lsb)
  );

  logic [DATA_W-1:0] reg_byte;
  psr_src_e          src;

  always_comb begin
    src = is_reg ? SRC_REG : SRC_MEM;
    if (!is_msb && held && (held_pair == pair_idx)) begin
      reg_byte = held_lsb;
    end else begin
      reg_byte = live_byte[reg_off];
    end
  end

  psr_outmux #(
    .DATA_W(DATA_W)
  ) u_outmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (rd_req),
    .src      (src),
    .reg_byte (reg_byte),
    .mem_rdata(mem_rdata),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign mem_req  = rd_req && !is_reg;
  assign mem_addr = rd_addr;

endmodule

// File: rtl/pair_snap_reader_checker.sv
module pair_snap_reader_checker #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int REG_BYTES = 32,
  localparam int REG_AW   = $clog2(REG_BYTES),
  localparam int LIVE_W   = REG_BYTES * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LIVE_W-1:0] live_regs,
  input logic              cmd_start,
  input logic              cmd_end,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              mem_req,
  input logic [DATA_W-1:0] mem_rdata
);

  logic              in_reg;
  logic              msb_now;
  logic [REG_AW-1:0] lsb_off;
  logic [DATA_W-1:0] lsb_now;

  always_comb begin
    in_reg  = (rd_addr < ADDR_W'(REG_BYTES));
    msb_now = rd_req && in_reg && !rd_addr[0] && !cmd_end;
    lsb_off = rd_addr[REG_AW-1:0] + REG_AW'(1);
    lsb_now = live_regs[lsb_off*DATA_W +: DATA_W];
  end

  // One-cycle memory of the last high-byte read and its partner's live value.
  logic              msb_seen_q;
  logic [ADDR_W-1:0] msb_addr_q;
  logic [DATA_W-1:0] lsb_snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_seen_q <= 1'b0;
      msb_addr_q <= '0;
      lsb_snap_q <= '0;
    end else begin
      msb_seen_q <= msb_now;
      msb_addr_q <= rd_addr;
      lsb_snap_q <= lsb_now;
    end
  end

  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  a_r7_mem_data_returned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (rd_data == mem_rdata));

  a_r3_lsb_matches_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (msb_seen_q && rd_req && !cmd_start && (rd_addr == msb_addr_q + ADDR_W'(1)))
    |=> (rd_data == $past(lsb_snap_q)));

endmodule

bind pair_snap_reader pair_snap_reader_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .REG_BYTES(REG_BYTES)
) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .live_regs(live_regs),
  .cmd_start(cmd_start),
  .cmd_end  (cmd_end),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .mem_req  (mem_req),
  .mem_rdata(mem_rdata)
);

// File: tb/pair_snap_reader_bench.sv
module pair_snap_reader_bench;

  localparam int NB = 32;

  logic           clk;
  logic           rst_n;
  logic [NB*8-1:0] live_regs;
  logic           cmd_start;
  logic           cmd_end;
  logic           rd_req;
  logic [7:0]     rd_addr;
  logic [7:0]     rd_data;
  logic           rd_valid;
  logic           mem_req;
  logic [7:0]     mem_addr;
  logic [7:0]     mem_rdata;

  logic [7:0] live [NB];
  int checks;
  int errors;

  always_comb begin
    for (int i = 0; i < NB; i++) live_regs[i*8 +: 8] = live[i];
  end

  pair_snap_reader u_pair_snap_reader (
    .clk      (clk),
    .rst_n    (rst_n),
    .live_regs(live_regs),
    .cmd_start(cmd_start),
    .cmd_end  (cmd_end),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // One-cycle memory model: data is a fixed function of the address.
  always @(posedge clk) begin
    if (mem_req) mem_rdata <= mem_addr ^ 8'h5A;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One read; optional end strobe in the same cycle. Returns data at next negedge.
  task automatic rd(input logic [7:0] a, input logic with_end, output logic [7:0] d);
    @(negedge clk);
    rd_req  = 1'b1;
    rd_addr = a;
    cmd_end = with_end;
    @(negedge clk);
    rd_req  = 1'b0;
    cmd_end = 1'b0;
    check("R2 valid", {7'd0, rd_valid}, 8'd1);
    d = rd_data;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk);
    cmd_end = 1'b1;
    @(negedge clk);
    cmd_end = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
    check("R1 mem_req", {7'd0, mem_req}, 8'd0);
    check("R1 rd_data", rd_data, 8'd0);
  endtask

  task automatic t_plain();
    logic [7:0] d;
    rd(8'd5, 1'b0, d);  check("R2 addr5", d, live[5]);
    rd(8'd31, 1'b0, d); check("R2 addr31", d, live[31]);
    rd(8'd0, 1'b0, d);  check("R2 addr0", d, live[0]);
  endtask

  task automatic t_coherent();
    logic [7:0] d;
    logic [7:0] old5;
    pulse_start();
    old5 = live[5];
    rd(8'd4, 1'b0, d); check("R3 msb", d, live[4]);
    live[4] = 8'hC1; live[5] = 8'hC2;
    rd(8'd5, 1'b0, d); check("R3 held lsb", d, old5);
    pulse_end();
    rd(8'd5, 1'b0, d); check("R4 released lsb", d, 8'hC2);
  endtask

  task automatic t_other();
    logic [7:0] d;
    pulse_start();
    rd(8'd10, 1'b0, d);
    live[7] = 8'h77;
    rd(8'd7, 1'b0, d); check("R5 other pair live", d, 8'h77);
    pulse_end();
  endtask

  task automatic t_reload();
    logic [7:0] d;
    logic [7:0] old13;
    pulse_start();
    rd(8'd10, 1'b0, d);
    old13 = live[13];
    rd(8'd12, 1'b0, d);
    live[11] = 8'hB1; live[13] = 8'hB3;
    rd(8'd11, 1'b0, d); check("R6 old pair live", d, 8'hB1);
    rd(8'd13, 1'b0, d); check("R6 new pair held", d, old13);
    pulse_end();
  endtask

  task automatic t_mem();
    logic [7:0] d;
    logic [7:0] old7;
    pulse_start();
    old7 = live[7];
    rd(8'd6, 1'b0, d);
    live[7] = 8'hE7;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 8'd40;
    #1;
    check("R7 mem_req", {7'd0, mem_req}, 8'd1);
    check("R7 mem_addr", mem_addr, 8'd40);
    @(negedge clk);
    rd_req = 1'b0;
    check("R7 mem data 40", rd_data, 8'd40 ^ 8'h5A);
    rd(8'd200, 1'b0, d); check("R7 mem data 200", d, 8'd200 ^ 8'h5A);
    rd(8'd7, 1'b0, d);   check("R7 capture kept", d, old7);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 8'd9;
    #1;
    check("R7 no mem_req in regs", {7'd0, mem_req}, 8'd0);
    @(negedge clk);
    rd_req = 1'b0;
    pulse_end();
  endtask

  task automatic t_rerd();
    logic [7:0] d;
    pulse_start();
    rd(8'd8, 1'b0, d);
    live[8] = 8'h88; live[9] = 8'h99;
    rd(8'd8, 1'b0, d); check("R8 msb fresh", d, 8'h88);
    rd(8'd9, 1'b0, d); check("R8 lsb recaptured", d, 8'h99);
    pulse_end();
  endtask

  task automatic t_start();
    logic [7:0] d;
    pulse_start();
    rd(8'd14, 1'b0, d);
    live[15] = 8'hF5;
    pulse_start();
    rd(8'd15, 1'b0, d); check("R9 start clears", d, 8'hF5);
    pulse_end();
  endtask

  task automatic t_endsame();
    logic [7:0] d;
    pulse_start();
    rd(8'd16, 1'b1, d); check("R10 msb with end", d, live[16]);
    live[17] = 8'hA7;
    rd(8'd17, 1'b0, d); check("R10 nothing held", d, 8'hA7);
  endtask

  task automatic t_idle();
    logic [7:0] d;
    rd(8'd3, 1'b0, d);
    @(negedge clk);
    check("R11 idle no valid", {7'd0, rd_valid}, 8'd0);
  endtask

  initial begin
    checks = 0; errors = 0;
    for (int i = 0; i < NB; i++) live[i] = 8'(i * 7 + 3);
    rst_n = 1'b0; cmd_start = 1'b0; cmd_end = 1'b0;
    rd_req = 1'b0; rd_addr = 8'd0; mem_rdata = 8'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_coherent();
    t_other();
    t_reload();
    t_mem();
    t_rerd();
    t_start();
    t_endsame();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule